// File: doc/BRIEF.md
# Zero-Suppressed Readout Sequencer

This block turns four stored conversion results into a short list of 16-bit words and delivers them on one of two paths. The first is a token-passing readout bus with a request line, a write strobe and acknowledge handshake, a readout-enable token input and a pass token output. The second is a register-style read path, where each read strobe returns the next word together with a "data valid" response.

A pulse on `ready` marks the end of conversion. On that pulse the block captures the results and formats them. With suppression off it produces four records, one per input, in channel order. With suppression on, zero results are left out and the records that remain are preceded by a header carrying the record count and the station number. Results above the overflow limit can be forced to zero first, so that they drop out under suppression. When there is nothing to send, the token passes straight through. A captured list stays in place until `clear` returns the block to idle.

Top module: `zs_readout_seq`

## Requirements
- R1: After reset, and in the cycle after `clear` is sampled high, `req`, `wst`, `pass` and `cam_q` are all low and the block is idle, ready to capture again.
- R2: With `cfg_keep_all`=1, the list is exactly four records for channels 0,1,2,3 in that order. Each record is {bit15=0, bits14:13=channel, bits12:0=data}, and the data of a channel whose `res_valid` bit is 0 reads as 0.
- R3: With `cfg_keep_all`=0, the list is one header followed by one record for each channel whose cleaned data is nonzero, in ascending channel order, giving 2 to 5 words in total.
- R4: The header has bit15=1, bits12:11 set to the record count modulo 4 (so 0 means four records), bits7:0 set to `cfg_vsn`, and every other bit 0.
- R5: Data above 8064 counts as overflow. With `cfg_ovf_keep`=0 an overflow value becomes 0, and is therefore dropped when suppression is on. With `cfg_ovf_keep`=1 it is kept unchanged. The value 8064 itself is not an overflow.
- R6: In bus mode (`cfg_cam_sel`=0 at capture), `req` goes high the cycle after a capture that has at least one word. It stays high until the last word is acknowledged, and it never rises for an empty list.
- R7: `wst` rises only while `ren` is high, and `out_word` holds the current word and stays stable while `wst` is high. `wst` falls only after a rising edge of `wak` has passed the input synchronizer. Each word is strobed once, in list order.
- R8: After the last word, `pass` equals `ren` and `req` is low. For an empty suppressed list, `pass` follows `ren` in the same cycle without any word being strobed. `pass` is always low while `ren` is low.
- R9: In register mode (`cfg_cam_sel`=1 at capture), `req`, `wst` and `pass` stay low. Each one-cycle `cam_rd` pulse gives `cam_q`=1 and the next word on `cam_word` in the following cycle. Once the list is used up, a read gives `cam_q`=0 and `cam_word`=0.
- R10: A `ready` pulse that arrives while a list is held (any state other than idle) is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear | input | 1 | Drop the held list and return to idle |
| ready | input | 1 | End-of-conversion pulse; captures the results |
| res_data | input | 52 | Four 13-bit results, channel 0 in the low bits |
| res_valid | input | 4 | One valid flag per channel |
| cfg_vsn | input | 8 | Station number placed in the header |
| cfg_keep_all | input | 1 | 1: no suppression; 0: header plus nonzero records |
| cfg_ovf_keep | input | 1 | 1: keep overflow values; 0: force them to zero |
| cfg_cam_sel | input | 1 | 1: register read path; 0: token bus |
| ren | input | 1 | Readout-enable token in |
| wak | input | 1 | Write acknowledge (asynchronous) |
| cam_rd | input | 1 | Register-path read strobe |
| req | output | 1 | Bus request |
| wst | output | 1 | Write strobe, marks a valid `out_word` |
| out_word | output | 16 | Bus data word |
| pass | output | 1 | Token out |
| cam_q | output | 1 | Register-path read response valid |
| cam_word | output | 16 | Register-path read data |

## Verification
The hardest cases to reach are the boundaries of the compaction logic. One is the four-record header whose count field wraps to 0. Another is a list that shrinks to nothing only because overflow forcing turned every nonzero result into zero, which makes the token pass with no word sent. Random trials draw each channel value from a weighted mix of zero, exactly 8064, values just above 8064, full scale and ordinary values, with random valid flags and modes. This mix makes those lists occur often, and directed cases pin each boundary down. Ignoring a late `ready` is checked by pulsing it after the list has been read out on the register path and confirming that the next read still reports no data.

// File: rtl/zsr_pkg.sv
package zsr_pkg;

    localparam int DATA_W = 13;
    localparam int WORD_W = 16;
    localparam int VSN_W  = 8;
    localparam int SUB_W  = 2;
    localparam int CNT_W  = 2;

    typedef logic [DATA_W-1:0] data_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic  present;
        word_t rec;
    } chan_rec_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_SEND,
        ST_GAP,
        ST_DONE,
        ST_EMPTY,
        ST_CAM
    } seq_state_t;

    function automatic word_t make_record(input logic [SUB_W-1:0] sub, input data_t d);
        return {1'b0, sub, d};
    endfunction

    function automatic word_t make_header(input logic [CNT_W-1:0] cnt, input logic [VSN_W-1:0] vsn);
        return {1'b1, 2'b00, cnt, 3'b000, vsn};
    endfunction

endpackage

// File: rtl/zsr_chan_fmt.sv
module zsr_chan_fmt
    import zsr_pkg::*;
#(
    parameter int CH_IDX    = 0,
    parameter int OVF_LIMIT = 8064
) (
    input  data_t     data_i,
    input  logic      valid_i,
    input  logic      keep_all_i,
    input  logic      ovf_keep_i,
    output chan_rec_t rec_o
);

    data_t clean;

    always_comb begin
        clean = valid_i ? data_i : '0;
        if (!ovf_keep_i && (int'(clean) > OVF_LIMIT))
            clean = '0;
        rec_o.present = keep_all_i || (clean != '0);
        rec_o.rec     = make_record(SUB_W'(CH_IDX), clean);
    end

endmodule

// File: rtl/zsr_pack.sv
module zsr_pack
    import zsr_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int MAXW  = NUM_CH + 1,
    localparam int IDX_W = $clog2(MAXW + 1)
) (
    input  chan_rec_t [NUM_CH-1:0] recs_i,
    input  logic                   keep_all_i,
    input  logic [VSN_W-1:0]       vsn_i,
    output word_t     [MAXW-1:0]   words_o,
    output logic      [IDX_W-1:0]  nwords_o
);

    logic [IDX_W-1:0] nrec;
    logic [IDX_W-1:0] pos;

    always_comb begin
        words_o = '0;
        nrec    = '0;
        pos     = IDX_W'(1);
        for (int i = 0; i < NUM_CH; i++)
            if (recs_i[i].present)
                nrec = nrec + IDX_W'(1);
        if (keep_all_i) begin
            for (int i = 0; i < NUM_CH; i++)
                words_o[i] = recs_i[i].rec;
            nwords_o = IDX_W'(NUM_CH);
        end else begin
            words_o[0] = make_header(nrec[CNT_W-1:0], vsn_i);
            for (int i = 0; i < NUM_CH; i++) begin
                if (recs_i[i].present) begin
                    words_o[pos] = recs_i[i].rec;
                    pos = pos + IDX_W'(1);
                end
            end
            nwords_o = (nrec == '0) ? '0 : nrec + IDX_W'(1);
        end
    end

endmodule

// File: rtl/zsr_bus_seq.sv
module zsr_bus_seq
    import zsr_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int SYNC_STAGES = 2,
    localparam int MAXW       = NUM_CH + 1,
    localparam int IDX_W      = $clog2(MAXW + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clear,
    input  logic                  ready,
    input  logic                  cam_sel_i,
    input  word_t [MAXW-1:0]      words_i,
    input  logic  [IDX_W-1:0]     nwords_i,
    input  logic                  ren,
    input  logic                  wak,
    input  logic                  cam_rd,
    output logic                  req,
    output logic                  wst,
    output word_t                 out_word,
    output logic                  pass,
    output logic                  cam_q,
    output word_t                 cam_word
);

    seq_state_t            state;
    logic [IDX_W-1:0]      idx;
    logic [IDX_W-1:0]      nheld;
    word_t [MAXW-1:0]      list;
    logic [SYNC_STAGES:0]  wak_sh;
    logic                  wak_edge;

    assign wak_edge = wak_sh[SYNC_STAGES-1] & ~wak_sh[SYNC_STAGES];

    always_ff @(posedge clk) begin
        if (rst) wak_sh <= '0;
        else     wak_sh <= {wak_sh[SYNC_STAGES-1:0], wak};
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            state    <= ST_IDLE;
            idx      <= '0;
            nheld    <= '0;
            list     <= '0;
            cam_q    <= 1'b0;
            cam_word <= '0;
        end else begin
            cam_q    <= 1'b0;
            cam_word <= '0;
            unique case (state)
                ST_IDLE: if (ready) begin
                    list  <= words_i;
                    nheld <= nwords_i;
                    idx   <= '0;
                    if (cam_sel_i)             state <= ST_CAM;
                    else if (nwords_i == '0)   state <= ST_EMPTY;
                    else                       state <= ST_WAIT;
                end
                ST_WAIT, ST_GAP: if (ren) state <= ST_SEND;
                ST_SEND: if (wak_edge) begin
                    if (idx == nheld - IDX_W'(1)) begin
                        state <= ST_DONE;
                    end else begin
                        idx   <= idx + IDX_W'(1);
                        state <= ST_GAP;
                    end
                end
                ST_CAM: if (cam_rd && (idx < nheld)) begin
                    cam_q    <= 1'b1;
                    cam_word <= list[idx];
                    idx      <= idx + IDX_W'(1);
                end
                default: ;
            endcase
        end
    end

    assign req      = (state == ST_WAIT) || (state == ST_SEND) || (state == ST_GAP);
    assign wst      = (state == ST_SEND);
    assign out_word = (state == ST_SEND) ? list[idx] : '0;
    assign pass     = ren && ((state == ST_DONE) || (state == ST_EMPTY));

endmodule

// File: rtl/zs_readout_seq.sv
module zs_readout_seq
    import zsr_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int OVF_LIMIT   = 8064,
    parameter int SYNC_STAGES = 2,
    localparam int MAXW       = NUM_CH + 1,
    localparam int IDX_W      = $clog2(MAXW + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clear,
    input  logic                     ready,
    input  logic [NUM_CH*DATA_W-1:0] res_data,
    input  logic [NUM_CH-1:0]        res_valid,
    input  logic [VSN_W-1:0]         cfg_vsn,
    input  logic                     cfg_keep_all,
    input  logic                     cfg_ovf_keep,
    input  logic                     cfg_cam_sel,
    input  logic                     ren,
    input  logic                     wak,
    input  logic                     cam_rd,
    output logic                     req,
    output logic                     wst,
    output logic [WORD_W-1:0]        out_word,
    output logic                     pass,
    output logic                     cam_q,
    output logic [WORD_W-1:0]        cam_word
);

    chan_rec_t [NUM_CH-1:0] recs;
    word_t     [MAXW-1:0]   words;
    logic      [IDX_W-1:0]  nwords;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        zsr_chan_fmt #(.CH_IDX(c), .OVF_LIMIT(OVF_LIMIT)) u_fmt (
            .data_i     (res_data[c*DATA_W +: DATA_W]),
            .valid_i    (res_valid[c]),
            .keep_all_i (cfg_keep_all),
            .ovf_keep_i (cfg_ovf_keep),
            .rec_o      (recs[c])
        );
    end

    zsr_pack #(.NUM_CH(NUM_CH)) u_pack (
        .recs_i     (recs),
        .keep_all_i (cfg_keep_all),
        .vsn_i      (cfg_vsn),
        .words_o    (words),
        .nwords_o   (nwords)
    );

    zsr_bus_seq #(.NUM_CH(NUM_CH), .SYNC_STAGES(SYNC_STAGES)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .clear     (clear),
        .ready     (ready),
        .cam_sel_i (cfg_cam_sel),
        .words_i   (words),
        .nwords_i  (nwords),
        .ren       (ren),
        .wak       (wak),
        .cam_rd    (cam_rd),
        .req       (req),
        .wst       (wst),
        .out_word  (out_word),
        .pass      (pass),
        .cam_q     (cam_q),
        .cam_word  (cam_word)
    );

endmodule

// File: rtl/zsr_checker.sv
module zsr_checker (
    input logic        clk,
    input logic        rst,
    input logic        clear,
    input logic        ren,
    input logic        wak,
    input logic        req,
    input logic        wst,
    input logic        pass,
    input logic        cam_q,
    input logic [15:0] out_word
);

    assert_clear_idle_R1: assert property (@(posedge clk) disable iff (rst)
        clear |=> (!req && !wst && !pass && !cam_q));

    assert_req_end_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(req) |-> (pass || !ren || $past(clear)));

    assert_word_stable_R7: assert property (@(posedge clk) disable iff (rst)
        (wst && $past(wst)) |-> $stable(out_word));

    assert_wst_after_wak_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(wst) |-> ($past(wak, 3) || $past(clear)));

    assert_wst_needs_ren_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(wst) |-> $past(ren));

    assert_pass_token_R8: assert property (@(posedge clk) disable iff (rst)
        pass |-> (ren && !req && !wst));

    assert_cam_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        cam_q |-> (!req && !wst && !pass));

endmodule

bind zs_readout_seq zsr_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .clear    (clear),
    .ren      (ren),
    .wak      (wak),
    .req      (req),
    .wst      (wst),
    .pass     (pass),
    .cam_q    (cam_q),
    .out_word (out_word)
);

// File: tb/tb_zs_readout_seq.sv
module tb_zs_readout_seq;

    logic        clk = 1'b0;
    logic        rst, clear, ready;
    logic [51:0] res_data;
    logic [3:0]  res_valid;
    logic [7:0]  cfg_vsn;
    logic        cfg_keep_all, cfg_ovf_keep, cfg_cam_sel;
    logic        ren, wak, cam_rd;
    logic        req, wst, pass, cam_q;
    logic [15:0] out_word, cam_word;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    logic [12:0] td [4];
    logic [15:0] exp_w [5];
    int          exp_n;

    always #5 clk = ~clk;

    zs_readout_seq dut (
        .clk(clk), .rst(rst), .clear(clear), .ready(ready),
        .res_data(res_data), .res_valid(res_valid), .cfg_vsn(cfg_vsn),
        .cfg_keep_all(cfg_keep_all), .cfg_ovf_keep(cfg_ovf_keep),
        .cfg_cam_sel(cfg_cam_sel), .ren(ren), .wak(wak), .cam_rd(cam_rd),
        .req(req), .wst(wst), .out_word(out_word), .pass(pass),
        .cam_q(cam_q), .cam_word(cam_word)
    );

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run hung, act=%0d cycles exp<150000", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic void model();
        logic [12:0] c;
        logic [15:0] recs [4];
        logic        pres [4];
        int          nr = 0;
        for (int i = 0; i < 4; i++) begin
            c = res_valid[i] ? td[i] : 13'd0;
            if (!cfg_ovf_keep && c > 13'd8064) c = 13'd0;
            pres[i] = cfg_keep_all || (c != 0);
            recs[i] = {1'b0, 2'(i), c};
            if (pres[i]) nr++;
        end
        for (int i = 0; i < 5; i++) exp_w[i] = 16'h0;
        if (cfg_keep_all) begin
            for (int i = 0; i < 4; i++) exp_w[i] = recs[i];
            exp_n = 4;
        end else begin
            exp_w[0] = {1'b1, 2'b00, 2'(nr), 3'b000, cfg_vsn};
            exp_n = 1;
            for (int i = 0; i < 4; i++)
                if (pres[i]) begin
                    exp_w[exp_n] = recs[i];
                    exp_n++;
                end
            if (nr == 0) exp_n = 0;
        end
    endfunction

    task automatic drive_data();
        for (int i = 0; i < 4; i++) res_data[i*13 +: 13] = td[i];
    endtask

    task automatic pulse_ready();
        @(negedge clk) ready = 1'b1;
        @(negedge clk) ready = 1'b0;
    endtask

    task automatic do_clear();
        @(negedge clk) clear = 1'b1;
        @(negedge clk) clear = 1'b0;
        chk("R1 idle after clear", {req, wst, pass, cam_q}, 4'b0000);
    endtask

    task automatic wait_wst(input logic lvl, output bit ok);
        ok = 1'b0;
        for (int t = 0; t < 40; t++) begin
            if (wst === lvl) begin ok = 1'b1; break; end
            @(negedge clk);
        end
    endtask

    task automatic run_bus();
        bit ok;
        string tag;
        chk("R6 req after capture", req, (exp_n > 0));
        if (exp_n == 0) begin
            chk("R8 no strobe on empty list", wst, 1'b0);
            @(negedge clk) ren = 1'b1;
            #1 chk("R8 empty list passes token at once", pass, 1'b1);
            chk("R8 empty list no request", req, 1'b0);
        end else begin
            @(negedge clk);
            chk("R7 no strobe before token", wst, 1'b0);
            ren = 1'b1;
            for (int k = 0; k < exp_n; k++) begin
                wait_wst(1'b1, ok);
                chk("R7 strobe arrives", ok, 1'b1);
                tag = cfg_keep_all ? "R2 record" : ((k == 0) ? "R4 header" : "R3 record");
                chk(tag, out_word, exp_w[k]);
                chk("R8 no pass during readout", pass, 1'b0);
                @(negedge clk);
                chk("R7 strobe held until ack", wst, 1'b1);
                wak = 1'b1;
                wait_wst(1'b0, ok);
                chk("R7 strobe released after ack", ok, 1'b1);
                wak = 1'b0;
                repeat (2) @(negedge clk);
            end
            repeat (3) @(negedge clk);
            chk("R7 no extra word", wst, 1'b0);
            chk("R8 pass after last word", pass, 1'b1);
            chk("R6 req released", req, 1'b0);
        end
        @(negedge clk) ren = 1'b0;
        #1 chk("R8 pass drops with token", pass, 1'b0);
    endtask

    task automatic cam_read(output logic q, output logic [15:0] w);
        @(negedge clk) cam_rd = 1'b1;
        @(negedge clk) cam_rd = 1'b0;
        q = cam_q;
        w = cam_word;
    endtask

    task automatic run_cam();
        logic q;
        logic [15:0] w;
        string tag;
        ren = 1'b1;
        @(negedge clk);
        chk("R9 no bus activity in register mode", {req, wst, pass}, 3'b000);
        for (int k = 0; k < exp_n; k++) begin
            cam_read(q, w);
            chk("R9 read valid", q, 1'b1);
            tag = cfg_keep_all ? "R2 record" : ((k == 0) ? "R4 header" : "R3 record");
            chk(tag, w, exp_w[k]);
        end
        cam_read(q, w);
        chk("R9 exhausted read", {q, w}, 17'h0);
        ren = 1'b0;
    endtask

    task automatic trial(input logic cam);
        drive_data();
        cfg_cam_sel = cam;
        model();
        pulse_ready();
        if (cam) run_cam();
        else     run_bus();
        do_clear();
    endtask

    function automatic logic [12:0] rand_val();
        int r = $urandom % 7;
        case (r)
            0:       return 13'd0;
            1:       return 13'd8064;
            2:       return 13'(8065 + ($urandom % 127));
            3:       return 13'd8191;
            default: return 13'(1 + ($urandom % 8063));
        endcase
    endfunction

    initial begin
        logic q;
        logic [15:0] w;
        void'($urandom(32'd1234));
        rst = 1'b1; clear = 1'b0; ready = 1'b0; res_data = '0; res_valid = '0;
        cfg_vsn = 8'h00; cfg_keep_all = 1'b0; cfg_ovf_keep = 1'b0; cfg_cam_sel = 1'b0;
        ren = 1'b0; wak = 1'b0; cam_rd = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset state", {req, wst, pass, cam_q}, 4'b0000);

        // R4: all four present, count field wraps to 0
        td = '{13'd5, 13'd100, 13'd2000, 13'd8000};
        res_valid = 4'hF; cfg_vsn = 8'hA5; cfg_keep_all = 0; cfg_ovf_keep = 0;
        trial(1'b0);

        // R5: 8064 kept, 8065 forced to zero and dropped
        td = '{13'd8064, 13'd8065, 13'd0, 13'd0};
        trial(1'b0);

        // R5: overflow kept when enabled
        td = '{13'd0, 13'd8191, 13'd0, 13'd3};
        cfg_ovf_keep = 1;
        trial(1'b0);

        // R8: only overflows, forced to zero -> empty list
        td = '{13'd8100, 13'd8191, 13'd0, 13'd8065};
        cfg_ovf_keep = 0;
        trial(1'b0);

        // R2: no suppression with an invalid channel
        td = '{13'd11, 13'd22, 13'd33, 13'd44};
        res_valid = 4'b1011; cfg_keep_all = 1;
        trial(1'b0);
        trial(1'b1);

        // R10: ready while a list is held is ignored
        td = '{13'd7, 13'd0, 13'd0, 13'd0};
        res_valid = 4'hF; cfg_keep_all = 0; cfg_cam_sel = 1;
        drive_data(); model();
        pulse_ready();
        for (int k = 0; k < exp_n; k++) cam_read(q, w);
        td = '{13'd9, 13'd9, 13'd9, 13'd9};
        drive_data();
        pulse_ready();
        cam_read(q, w);
        chk("R10 late ready ignored", {q, w}, 17'h0);
        do_clear();

        for (int n = 0; n < 40; n++) begin
            for (int i = 0; i < 4; i++) td[i] = rand_val();
            res_valid    = 4'($urandom);
            if (($urandom % 3) != 0) res_valid = 4'hF;
            cfg_vsn      = 8'($urandom);
            cfg_keep_all = (($urandom % 4) == 0);
            cfg_ovf_keep = 1'($urandom);
            trial(1'($urandom));
        end

        summary();
        $finish;
    end

endmodule